// File: doc/BRIEF.md
# Power-Fail Store/Recall Sequencer

This block decides when the nonvolatile shadow copy of an SRAM is written or reloaded. It watches a low-supply flag that has already been synchronized, the strobes of the host SRAM port, and two one-cycle software requests. It drives four phase outputs to an abstracted array. A save is an erase phase followed by a program phase. A reload is a clear phase followed by a transfer phase. It also drives a busy flag, a host I/O disable and a write block for the host port.

When the supply drops, the block first gives any access already under way a short grace window. It then saves the array, but only if some write has completed since the last save or reload. After that it waits until the supply is back and reloads the array. A reload also runs after reset, once the supply is good. Software can ask for a save or a reload at any time the block is idle. A software save is refused while the supply is low. Every phase length is a parameter in clock cycles.

Top module: `nv_shadow_seq`

## Requirements
- R1: Out of reset the block is waiting for supply: `io_off_o`=1, `wr_block_o`=1, `busy_o`=0 and all phase outputs are 0. On the first clock edge with `vlow_i`=0 it starts a reload whose clear phase lasts T_CLR cycles and whose transfer phase lasts T_RESTORE-T_CLR cycles.
- R2: Every reload raises `clear_o` first and `xfer_o` right after it. At most one of `erase_o`, `prog_o`, `clear_o` and `xfer_o` is high in any cycle.
- R3: A software save in idle with `vlow_i`=0 runs `erase_o` for T_ERASE cycles, then `prog_o` for T_PROG cycles, then returns to idle. It does this whether or not the dirty flag is set.
- R4: A software save request is ignored when `vlow_i` is 1 in the same cycle. No erase phase follows unless the power-fail save is itself due.
- R5: When `vlow_i` rises in idle and the dirty flag is clear, no save is made. The block goes straight to the supply wait state, with `io_off_o`=1 and `busy_o`=0.
- R6: `dirty_o` is set by a `wr_done_i` pulse in idle or in the grace window. It is cleared when a save or a reload completes. A pulse in any other state has no effect.
- R7: If `acc_busy_i` is high when the supply loss is seen, the save waits in a grace window. The window ends on the first cycle with `acc_busy_i` low, or after T_GRACE cycles, whichever comes first. A write that completes inside the window makes the save happen.
- R8: `wr_block_o` is high whenever `vlow_i` is high, during the grace window, and during every phase and wait state.
- R9: `io_off_o` is high during all four phases and the supply wait, and low in idle and in the grace window. `busy_o` is high in the grace window and in all four phases only.
- R10: A software reload runs a clear phase of T_CLR cycles, then a transfer phase of T_SWRCL-T_CLR cycles. It is accepted even when `vlow_i` is high.
- R11: If a software reload and a software save arrive in the same cycle, only the reload runs.
- R12: After a power-fail save, or a save that was skipped, the block holds in the supply wait state while `vlow_i` is 1. It starts a reload on the first edge with `vlow_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vlow_i | input | 1 | Synchronized supply-below-threshold flag |
| acc_busy_i | input | 1 | Host SRAM access currently in progress |
| wr_done_i | input | 1 | One-cycle pulse: a host write has completed |
| sw_store_i | input | 1 | One-cycle software save request |
| sw_recall_i | input | 1 | One-cycle software reload request |
| erase_o | output | 1 | Save phase 1: erase the nonvolatile copy |
| prog_o | output | 1 | Save phase 2: program the nonvolatile copy |
| clear_o | output | 1 | Reload phase 1: clear the SRAM |
| xfer_o | output | 1 | Reload phase 2: copy nonvolatile data into the SRAM |
| busy_o | output | 1 | Grace window or any save/reload phase active |
| io_off_o | output | 1 | Host port inputs and outputs disabled |
| wr_block_o | output | 1 | New host writes refused |
| dirty_o | output | 1 | A write has completed since the last save or reload |

## Verification
Some rules are checked by assertions on every cycle. These are: a reload request wins over a save request, and a low supply blocks a software save. The grace window ends on the first cycle with the access done. A clean array skips the save, the supply wait holds while the supply is low, and the dirty flag clears when an operation completes. Other behaviour only shows up in the bench scenarios. That covers the exact phase lengths and their order, and the grace length swept across every access duration around T_GRACE. It also covers a write finishing inside the window, and the cycle counts of the port disable and write block outputs.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_ERASE,
    ST_PROG,
    ST_CLEAR,
    ST_XFER,
    ST_DOWN
  } seq_state_e;
endpackage

// File: rtl/nv_seq_timer.sv
module nv_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nv_seq_dirty.sv
module nv_seq_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_done_i,
  input  logic accept_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       dirty_q <= 1'b0;
    else if (clr_i)                    dirty_q <= 1'b0;
    else if (wr_done_i && accept_i)    dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;

  // R6: completion always leaves the array clean
  a_r6_clear_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dirty_o);
  // R6: a write outside the accepting states changes nothing
  a_r6_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done_i && !accept_i && !clr_i) |=> $stable(dirty_o));
endmodule

// File: rtl/nv_seq_fsm.sv
module nv_seq_fsm
  import nv_seq_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned T_GRACE   = 4,
  parameter int unsigned T_ERASE   = 4,
  parameter int unsigned T_PROG    = 4,
  parameter int unsigned T_CLR     = 2,
  parameter int unsigned T_RESTORE = 8,
  parameter int unsigned T_SWRCL   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vlow_i,
  input  logic          acc_busy_i,
  input  logic          sw_store_i,
  input  logic          sw_recall_i,
  input  logic          pending_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output seq_state_e    state_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LD_GRACE = CW'(T_GRACE - 1);
  localparam logic [CW-1:0] LD_ERASE = CW'(T_ERASE - 1);
  localparam logic [CW-1:0] LD_PROG  = CW'(T_PROG - 1);
  localparam logic [CW-1:0] LD_CLR   = CW'(T_CLR - 1);
  localparam logic [CW-1:0] LD_XA    = CW'(T_RESTORE - T_CLR - 1);
  localparam logic [CW-1:0] LD_XS    = CW'(T_SWRCL - T_CLR - 1);

  seq_state_e state_q, state_d;
  logic       auto_q, auto_d;  // current operation was started by power events

  always_comb begin
    state_d    = state_q;
    auto_d     = auto_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_recall_i) begin
          state_d = ST_CLEAR; auto_d = 1'b0; load_o = 1'b1; load_val_o = LD_CLR;
        end else if (vlow_i) begin
          if (acc_busy_i) begin
            state_d = ST_GRACE; load_o = 1'b1; load_val_o = LD_GRACE;
          end else if (pending_i) begin
            state_d = ST_ERASE; auto_d = 1'b1; load_o = 1'b1; load_val_o = LD_ERASE;
          end else begin
            state_d = ST_DOWN; auto_d = 1'b1;
          end
        end else if (sw_store_i) begin
          state_d = ST_ERASE; auto_d = 1'b0; load_o = 1'b1; load_val_o = LD_ERASE;
        end
      end
      ST_GRACE: begin
        if (!acc_busy_i || zero_i) begin
          if (pending_i) begin
            state_d = ST_ERASE; auto_d = 1'b1; load_o = 1'b1; load_val_o = LD_ERASE;
          end else begin
            state_d = ST_DOWN; auto_d = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (zero_i) begin
          state_d = ST_PROG; load_o = 1'b1; load_val_o = LD_PROG;
        end
      end
      ST_PROG: begin
        if (zero_i) state_d = auto_q ? ST_DOWN : ST_IDLE;
      end
      ST_CLEAR: begin
        if (zero_i) begin
          state_d = ST_XFER; load_o = 1'b1; load_val_o = auto_q ? LD_XA : LD_XS;
        end
      end
      ST_XFER: begin
        if (zero_i) state_d = ST_IDLE;
      end
      ST_DOWN: begin
        if (!vlow_i) begin
          state_d = ST_CLEAR; auto_d = 1'b1; load_o = 1'b1; load_val_o = LD_CLR;
        end
      end
      default: state_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DOWN;
      auto_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = zero_i && ((state_q == ST_PROG) || (state_q == ST_XFER));

  a_r11_recall_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && sw_recall_i) |=> state_q == ST_CLEAR);
  a_r4_no_store_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && vlow_i && !pending_i && !sw_recall_i) |=> state_q != ST_ERASE);
  a_r7_grace_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRACE && !acc_busy_i) |=> state_q != ST_GRACE);
  a_r5_skip_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRACE && !acc_busy_i && !pending_i) |=> state_q == ST_DOWN);
  a_r12_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOWN && vlow_i) |=> state_q == ST_DOWN);
  a_r2_xfer_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && $past(state_q) != ST_XFER) |-> $past(state_q) == ST_CLEAR);
endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
  import nv_seq_pkg::*;
#(
  parameter int unsigned T_GRACE   = 100,
  parameter int unsigned T_ERASE   = 500000,
  parameter int unsigned T_PROG    = 500000,
  parameter int unsigned T_CLR     = 200,
  parameter int unsigned T_RESTORE = 65000,
  parameter int unsigned T_SWRCL   = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vlow_i,
  input  logic acc_busy_i,
  input  logic wr_done_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  output logic erase_o,
  output logic prog_o,
  output logic clear_o,
  output logic xfer_o,
  output logic busy_o,
  output logic io_off_o,
  output logic wr_block_o,
  output logic dirty_o
);
  localparam int unsigned M1   = (T_ERASE > T_PROG) ? T_ERASE : T_PROG;
  localparam int unsigned M2   = (T_RESTORE > T_SWRCL) ? T_RESTORE : T_SWRCL;
  localparam int unsigned M3   = (M1 > M2) ? M1 : M2;
  localparam int unsigned TMAX = (M3 > T_GRACE) ? M3 : T_GRACE;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  seq_state_e    state;
  logic          load, zero, done, pending, dirty_q;
  logic [CW-1:0] load_val;

  assign pending = dirty_q | wr_done_i;  // write finishing this cycle counts

  nv_seq_fsm #(
    .CW(CW), .T_GRACE(T_GRACE), .T_ERASE(T_ERASE), .T_PROG(T_PROG),
    .T_CLR(T_CLR), .T_RESTORE(T_RESTORE), .T_SWRCL(T_SWRCL)
  ) i_fsm (
    .clk_i, .rst_ni, .vlow_i, .acc_busy_i, .sw_store_i, .sw_recall_i,
    .pending_i(pending), .zero_i(zero), .load_o(load), .load_val_o(load_val),
    .state_o(state), .done_o(done)
  );

  nv_seq_timer #(.CW(CW)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .zero_o(zero)
  );

  nv_seq_dirty i_dirty (
    .clk_i, .rst_ni, .wr_done_i,
    .accept_i((state == ST_IDLE) || (state == ST_GRACE)),
    .clr_i(done), .dirty_o(dirty_q)
  );

  assign erase_o    = (state == ST_ERASE);
  assign prog_o     = (state == ST_PROG);
  assign clear_o    = (state == ST_CLEAR);
  assign xfer_o     = (state == ST_XFER);
  assign busy_o     = (state != ST_IDLE) && (state != ST_DOWN);
  assign io_off_o   = (state != ST_IDLE) && (state != ST_GRACE);
  assign wr_block_o = (state != ST_IDLE) || vlow_i;
  assign dirty_o    = dirty_q;

  a_r2_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, prog_o, clear_o, xfer_o}));
  a_r3_prog_after_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(erase_o));
endmodule

// File: tb/test_nv_shadow_seq.sv
module test_nv_shadow_seq;
  localparam int TG = 4, TE = 3, TP = 5, TC = 2, TR = 6, TS = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic vlow_i = 1'b1, acc_busy_i = 1'b0, wr_done_i = 1'b0;
  logic sw_store_i = 1'b0, sw_recall_i = 1'b0;
  logic erase_o, prog_o, clear_o, xfer_o, busy_o, io_off_o, wr_block_o, dirty_o;

  int checks = 0, failures = 0;
  int n_er, n_pr, n_cl, n_xf, n_busy, n_io, n_wb, f_er, f_pr, f_cl, f_xf;

  always #4 clk_i = ~clk_i;

  nv_shadow_seq #(
    .T_GRACE(TG), .T_ERASE(TE), .T_PROG(TP), .T_CLR(TC), .T_RESTORE(TR), .T_SWRCL(TS)
  ) i_nv_shadow_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // count phase cycles over n samples; optional access drop and write pulse
  task automatic obs(input int n, input int busy_len, input int wd_at);
    n_er = 0; n_pr = 0; n_cl = 0; n_xf = 0; n_busy = 0; n_io = 0; n_wb = 0;
    f_er = -1; f_pr = -1; f_cl = -1; f_xf = -1;
    @(posedge clk_i); #1;
    sw_store_i = 0; sw_recall_i = 0; wr_done_i = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (erase_o) begin if (f_er < 0) f_er = i; n_er++; end
      if (prog_o)  begin if (f_pr < 0) f_pr = i; n_pr++; end
      if (clear_o) begin if (f_cl < 0) f_cl = i; n_cl++; end
      if (xfer_o)  begin if (f_xf < 0) f_xf = i; n_xf++; end
      if (busy_o) n_busy++;
      if (io_off_o) n_io++;
      if (wr_block_o) n_wb++;
      if (busy_len > 0 && i == busy_len - 1) acc_busy_i = 0;
      if (i == wd_at) wr_done_i = 1;
      else if (i == wd_at + 1) wr_done_i = 0;
    end
    wr_done_i = 0;
  endtask

  task automatic do_write();
    tick(); wr_done_i = 1;
    obs(2, 0, -1);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    // R1: reset state while supply low
    chk("R1 io_off", io_off_o, 1);
    chk("R1 wr_block", wr_block_o, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 phases", {erase_o, prog_o, clear_o, xfer_o}, 0);
    chk("R6 dirty reset", dirty_o, 0);
    tick(); vlow_i = 0;
    obs(12, 0, -1);
    chk("R1 clear len", n_cl, TC);
    chk("R1 xfer len", n_xf, TR - TC);
    chk("R2 clear first", f_cl, 0);
    chk("R2 xfer follows", f_xf, TC);
    chk("R9 busy len", n_busy, TR);
    chk("R9 io_off len", n_io, TR);
    chk("R2 no save", n_er + n_pr, 0);

    do_write();
    chk("R6 dirty set", dirty_o, 1);
    chk("R8 idle writes open", wr_block_o, 0);

    // R3: software save with dirty array
    tick(); sw_store_i = 1;
    obs(12, 0, -1);
    chk("R3 erase len", n_er, TE);
    chk("R3 erase first", f_er, 0);
    chk("R3 prog len", n_pr, TP);
    chk("R3 prog follows", f_pr, TE);
    chk("R9 busy store", n_busy, TE + TP);
    chk("R6 dirty cleared", dirty_o, 0);
    chk("R9 idle io", io_off_o, 0);

    // R3: software save with clean array still runs
    tick(); sw_store_i = 1;
    obs(12, 0, -1);
    chk("R3 clean erase", n_er, TE);
    chk("R3 clean prog", n_pr, TP);

    // R10: software reload
    tick(); sw_recall_i = 1;
    obs(8, 0, -1);
    chk("R10 clear len", n_cl, TC);
    chk("R10 xfer len", n_xf, TS - TC);
    chk("R10 xfer follows", f_xf, TC);
    chk("R9 io_off reload", n_io, TS);

    // R11: both requests in one cycle
    do_write();
    tick(); sw_recall_i = 1; sw_store_i = 1;
    obs(10, 0, -1);
    chk("R11 reload runs", n_cl, TC);
    chk("R11 xfer runs", n_xf, TS - TC);
    chk("R11 no save", n_er + n_pr, 0);
    chk("R6 dirty after reload", dirty_o, 0);

    // R7: grace sweep across access lengths
    for (int k = 0; k <= TG + 2; k++) begin
      int g;
      g = (k < TG) ? k : TG;
      do_write();
      tick(); vlow_i = 1; acc_busy_i = (k > 0);
      obs(20, k, -1);
      chk("R7 grace len", f_er, g);
      chk("R7 erase len", n_er, TE);
      chk("R7 prog follows", f_pr, g + TE);
      chk("R9 busy power save", n_busy, g + TE + TP);
      chk("R9 io_off power save", n_io, 20 - g);
      chk("R8 write block", n_wb, 20);
      chk("R12 hold low", io_off_o, 1);
      tick(); vlow_i = 0;
      obs(8, 0, -1);
      chk("R12 reload clear", n_cl, TC);
      chk("R12 reload xfer", n_xf, TR - TC);
      chk("R6 dirty after power cycle", dirty_o, 0);
    end

    // R4/R5: clean array, save request together with supply loss
    tick(); vlow_i = 1; sw_store_i = 1;
    obs(10, 0, -1);
    chk("R4 no erase", n_er, 0);
    chk("R5 no busy", n_busy, 0);
    chk("R5 wait io_off", n_io, 10);
    // R6: write pulse in wait state ignored
    tick(); wr_done_i = 1;
    obs(2, 0, -1);
    chk("R6 ignored write", dirty_o, 0);
    tick(); vlow_i = 0;
    obs(8, 0, -1);
    chk("R12 reload after skip", n_cl, TC);

    // R7: write completing inside grace forces the save
    tick(); vlow_i = 1; acc_busy_i = 1;
    obs(20, 3, 2);
    chk("R7 late write grace", f_er, 3);
    chk("R7 late write save", n_er, TE);
    chk("R7 late write prog", n_pr, TP);
    tick(); vlow_i = 0;
    obs(8, 0, -1);

    // R5: busy access ends, clean array -> skip
    tick(); vlow_i = 1; acc_busy_i = 1;
    obs(10, 2, -1);
    chk("R5 grace then skip", n_er, 0);
    chk("R5 grace busy", n_busy, 2);
    tick(); vlow_i = 0;
    obs(8, 0, -1);

    // R10: reload accepted with low supply, then no save (clean)
    do_write();
    tick(); sw_recall_i = 1; vlow_i = 1;
    obs(16, 0, -1);
    chk("R10 low clear", n_cl, TC);
    chk("R10 low xfer", n_xf, TS - TC);
    chk("R10 no save after", n_er, 0);
    chk("R12 waits", io_off_o, 1);
    tick(); vlow_i = 0;
    obs(8, 0, -1);
    chk("R12 final reload", n_xf, TR - TC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule